// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block turns one active-low cold power-on reset and five warm reset requests into four reset outputs, each for its own clock domain. Every output goes low at once, with no clock needed, and comes out of reset only after a short chain of flops clocked by the domain it feeds. The cold reset drives all four outputs. The warm requests drive only the system reset and the fabric reset. The clock-controller reset is left alone by any warm event.

The five warm sources are: a software reset request from the processor, the processor's active-low lockup indication, a watchdog timeout pulse, an active-low startup reset from the system controller, and an active-low reset request from the programmable fabric. Each source is synchronized to the processor clock. While any source is active, and for a fixed stretch afterwards, the system reset is held. A sticky flag records each source that caused a reset, and a flag marks that a power-on occurred. Software reads the flags on a vector output and clears them through a write-one-to-clear strobe. The flag register is cleared only by the cold reset, so the flags survive the warm resets they record.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `por_sync_n`, `sys_rst_n`, `cc_por_n` and `fab_rst_n` are low without waiting for any clock edge. The flag vector `cause_flags` is 6'b000001.
- R2: After `por_n` rises, `por_sync_n` and `sys_rst_n` go high on the second `clk_cpu` rising edge, `cc_por_n` on the second `clk_cc` edge and `fab_rst_n` on the second `clk_fab` edge. `sys_rst_n` is never high while `por_sync_n` is low.
- R3: `cc_por_n` is driven by `por_n` only. No warm source ever pulls it low.
- R4: Each warm source asserts the system reset: `sw_req` high, `lockup_n` low, `wdog_tmo` high, `boot_rst_n` low or `fab_req_n` low. A source applied before a `clk_cpu` edge E1 drives `sys_rst_n` and `fab_rst_n` low right after edge E3, and not before. A pulse one cycle wide is enough.
- R5: After the last active warm source has cleared, `sys_rst_n` stays low for at least 16 `clk_cpu` cycles. Take a source applied before edge E1 and removed before edge E(h+1). `sys_rst_n` rises right after edge E(h+21).
- R6: The bits of `cause_flags` are assigned as follows: bit 0 power-on, bit 1 software request, bit 2 lockup, bit 3 watchdog, bit 4 startup, bit 5 fabric. A warm source sets its bit on the same edge that first asserts the system reset, and every source active at that time sets its bit.
- R7: When `cause_clr_we` is high on a `clk_cpu` edge, each `cause_flags` bit whose `cause_clr_mask` bit is 1 is cleared. A mask bit of 0 leaves its flag unchanged. A source that is active on the same edge as its clear keeps its bit set. A warm reset never clears any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor clock; clocks the flags, the warm logic, `por_sync_n` and `sys_rst_n` |
| clk_cc | input | 1 | Clock of the clock-alignment controller domain |
| clk_fab | input | 1 | Fabric clock |
| por_n | input | 1 | Cold power-on reset, active low, asynchronous |
| sw_req | input | 1 | Processor software reset request, active high |
| lockup_n | input | 1 | Processor lockup (fault inside a fault or NMI handler), active low |
| wdog_tmo | input | 1 | Watchdog timeout event, active high |
| boot_rst_n | input | 1 | Startup reset from the system controller, active low |
| fab_req_n | input | 1 | Reset request from the fabric, active low |
| cause_clr_we | input | 1 | Write strobe for clearing flags |
| cause_clr_mask | input | 6 | Write-one-to-clear mask, using the bit positions of R6 |
| por_sync_n | output | 1 | Power-on reset synchronized to `clk_cpu`, for the register block |
| sys_rst_n | output | 1 | System reset for the processor subsystem |
| cc_por_n | output | 1 | Power-on reset for the clock-alignment controller |
| fab_rst_n | output | 1 | Reset for the fabric domain |
| cause_flags | output | 6 | Sticky reset-cause flags |

## Verification
The assertions take the following for granted about the inputs:
- `por_n` is low at time zero.
- Every warm request is level-sampled on `clk_cpu` and lasts at least one processor cycle, so each event reaches the synchronizers.
- The clear strobe and mask are stable around each `clk_cpu` edge.

The stimulus respects all of this. Every input changes on a falling edge of `clk_cpu`. Each warm pattern is held for one to five whole cycles. The cold reset is released away from the rising edges of all three clocks.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // number of warm reset sources and width of the flag vector (bit 0 = power-on)
  localparam int unsigned N_WARM  = 5;
  localparam int unsigned CAUSE_W = N_WARM + 1;

  // bit positions of the warm sources inside the synchronized request vector
  localparam int unsigned IDX_SW      = 0;
  localparam int unsigned IDX_LOCKUP  = 1;
  localparam int unsigned IDX_WDOG    = 2;
  localparam int unsigned IDX_STARTUP = 3;
  localparam int unsigned IDX_FABRIC  = 4;

  // next value of the post-release stretch counter
  function automatic int unsigned stretch_next(int unsigned cur, logic hit, int unsigned load);
    if (hit) return load;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // sticky flags: clear by mask first, then set, so a set wins over a clear
  function automatic logic [CAUSE_W-1:0] flags_next(logic [CAUSE_W-1:0] cur,
                                                    logic [CAUSE_W-1:0] set,
                                                    logic [CAUSE_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rst_seq_arst_sync.sv
module rst_seq_arst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  // assertion is asynchronous, release walks a one through the chain
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];

  // R2: once released, the output stays high while its clear input stays high
  p_release_holds_r2: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n |=> rst_n);

endmodule

// File: rtl/rst_seq_lvl_sync.sv
module rst_seq_lvl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/rst_seq_warm_ctrl.sv
module rst_seq_warm_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WARM-1:0]  src,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic               active,
  output logic [CAUSE_W-1:0] cause
);

  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic               any_src;
  logic [CNT_W-1:0]   cnt_q;
  logic               active_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] clr_vec;

  assign any_src = |src;
  assign set_vec = {src, 1'b0};
  assign clr_vec = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= CNT_W'(stretch_next(32'(cnt_q), any_src, HOLD));
      active_q <= any_src || (cnt_q != '0);
    end
  end

  // power-on bit resets to one; only the cold reset reaches this register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_W'(1);
    else        cause_q <= flags_next(cause_q, set_vec, clr_vec);
  end

  assign active = active_q;
  assign cause  = cause_q;

  // checker: processor cycles since the last active source, saturating at HOLD
  logic [CNT_W-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   quiet_q <= '0;
    else if (any_src)             quiet_q <= '0;
    else if (quiet_q != CNT_W'(HOLD)) quiet_q <= quiet_q + 1'b1;
  end

  // R5: the request falls only after HOLD quiet cycles
  p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (quiet_q == CNT_W'(HOLD)));

  // R4: any synchronized source asserts the request on the next edge
  p_src_asserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> active_q);

  for (genvar gi = 0; gi < N_WARM; gi++) begin : g_cause_chk
    // R6: an active source records its cause
    p_cause_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      src[gi] |=> cause_q[gi+1]);
  end

  for (genvar gk = 0; gk < CAUSE_W; gk++) begin : g_sticky_chk
    // R7: a flag drops only through a masked clear write
    p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[gk] && !(clr_we && clr_mask[gk])) |=> cause_q[gk]);
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic               clk_cpu,
  input  logic               clk_cc,
  input  logic               clk_fab,
  input  logic               por_n,
  input  logic               sw_req,
  input  logic               lockup_n,
  input  logic               wdog_tmo,
  input  logic               boot_rst_n,
  input  logic               fab_req_n,
  input  logic               cause_clr_we,
  input  logic [CAUSE_W-1:0] cause_clr_mask,
  output logic               por_sync_n,
  output logic               sys_rst_n,
  output logic               cc_por_n,
  output logic               fab_rst_n,
  output logic [CAUSE_W-1:0] cause_flags
);

  localparam int unsigned N_DOM   = 4;
  localparam int unsigned DOM_POR = 0;
  localparam int unsigned DOM_SYS = 1;
  localparam int unsigned DOM_CC  = 2;
  localparam int unsigned DOM_FAB = 3;

  logic [N_WARM-1:0] req_raw;
  logic [N_WARM-1:0] req_sync;
  logic              warm_active;
  logic [N_DOM-1:0]  dom_clk;
  logic [N_DOM-1:0]  dom_clr_n;
  logic [N_DOM-1:0]  dom_rst_n;

  // normalise every warm request to active high
  always_comb begin
    req_raw              = '0;
    req_raw[IDX_SW]      = sw_req;
    req_raw[IDX_LOCKUP]  = ~lockup_n;
    req_raw[IDX_WDOG]    = wdog_tmo;
    req_raw[IDX_STARTUP] = ~boot_rst_n;
    req_raw[IDX_FABRIC]  = ~fab_req_n;
  end

  for (genvar gs = 0; gs < N_WARM; gs++) begin : g_req_sync
    rst_seq_lvl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
      .clk   (clk_cpu),
      .rst_n (por_sync_n),
      .d     (req_raw[gs]),
      .q     (req_sync[gs])
    );
  end

  rst_seq_warm_ctrl #(.HOLD(HOLD_CYCLES)) i_warm (
    .clk      (clk_cpu),
    .rst_n    (por_sync_n),
    .src      (req_sync),
    .clr_we   (cause_clr_we),
    .clr_mask (cause_clr_mask),
    .active   (warm_active),
    .cause    (cause_flags)
  );

  // per-domain clock and asynchronous clear
  always_comb begin
    dom_clk            = '0;
    dom_clr_n          = '0;
    dom_clk[DOM_POR]   = clk_cpu;
    dom_clk[DOM_SYS]   = clk_cpu;
    dom_clk[DOM_CC]    = clk_cc;
    dom_clk[DOM_FAB]   = clk_fab;
    dom_clr_n[DOM_POR] = por_n;
    dom_clr_n[DOM_SYS] = por_n & ~warm_active;
    dom_clr_n[DOM_CC]  = por_n;
    dom_clr_n[DOM_FAB] = por_n & ~warm_active;
  end

  for (genvar gd = 0; gd < N_DOM; gd++) begin : g_dom
    rst_seq_arst_sync #(.STAGES(SYNC_STAGES)) i_rsync (
      .clk    (dom_clk[gd]),
      .arst_n (dom_clr_n[gd]),
      .rst_n  (dom_rst_n[gd])
    );
  end

  assign por_sync_n = dom_rst_n[DOM_POR];
  assign sys_rst_n  = dom_rst_n[DOM_SYS];
  assign cc_por_n   = dom_rst_n[DOM_CC];
  assign fab_rst_n  = dom_rst_n[DOM_FAB];

  // R2: system reset never releases ahead of the synchronized power-on reset
  p_sys_after_por_r2: assert property (@(posedge clk_cpu) disable iff (!por_n)
    !por_sync_n |-> !sys_rst_n);

  // R3: warm activity cannot pull the clock-controller reset low
  p_cc_warm_blind_r3: assert property (@(posedge clk_cc) disable iff (!por_n)
    cc_por_n |=> cc_por_n);

  // R4: a pending warm request holds both warm-driven outputs low
  p_warm_outputs_r4: assert property (@(posedge clk_cpu) disable iff (!por_n)
    warm_active |-> (!sys_rst_n && !fab_rst_n));

endmodule

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;

  localparam int CLK_P     = 10;
  localparam int CLK_CC_P  = 16;
  localparam int CLK_FAB_P = 12;
  localparam int HOLD      = 16;
  localparam int SYNC      = 2;
  localparam int N_VEC     = 8;

  // {warm pattern (bit0 sw, bit1 lockup, bit2 wdog, bit3 startup, bit4 fabric), hold cycles}
  localparam logic [12:0] VEC_TBL [N_VEC] = '{
    {5'b00001, 8'd1}, {5'b00010, 8'd3}, {5'b00100, 8'd1}, {5'b01000, 8'd5},
    {5'b10000, 8'd2}, {5'b10101, 8'd4}, {5'b11111, 8'd3}, {5'b00110, 8'd1}
  };

  logic clk_cpu = 1'b0, clk_cc = 1'b0, clk_fab = 1'b0;
  logic por_n, sw_req, lockup_n, wdog_tmo, boot_rst_n, fab_req_n;
  logic cause_clr_we;
  logic [5:0] cause_clr_mask;
  logic por_sync_n, sys_rst_n, cc_por_n, fab_rst_n;
  logic [5:0] cause_flags;

  int vectors = 0;
  int miscmp  = 0;

  always #(CLK_P/2)     clk_cpu = ~clk_cpu;
  always #(CLK_CC_P/2)  clk_cc  = ~clk_cc;
  always #(CLK_FAB_P/2) clk_fab = ~clk_fab;

  rst_seq_ctrl i_rst_seq_ctrl (
    .clk_cpu(clk_cpu), .clk_cc(clk_cc), .clk_fab(clk_fab), .por_n(por_n),
    .sw_req(sw_req), .lockup_n(lockup_n), .wdog_tmo(wdog_tmo),
    .boot_rst_n(boot_rst_n), .fab_req_n(fab_req_n),
    .cause_clr_we(cause_clr_we), .cause_clr_mask(cause_clr_mask),
    .por_sync_n(por_sync_n), .sys_rst_n(sys_rst_n), .cc_por_n(cc_por_n),
    .fab_rst_n(fab_rst_n), .cause_flags(cause_flags)
  );

  task automatic chk(input logic [5:0] got, input logic [5:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p);
    sw_req     = p[0];
    lockup_n   = ~p[1];
    wdog_tmo   = p[2];
    boot_rst_n = ~p[3];
    fab_req_n  = ~p[4];
  endtask

  // one processor edge, then sample at the following falling edge
  task automatic step();
    @(posedge clk_cpu);
    @(negedge clk_cpu);
  endtask

  task automatic clear_flags(input logic [5:0] m);
    cause_clr_we   = 1'b1;
    cause_clr_mask = m;
    step();
    cause_clr_we   = 1'b0;
    cause_clr_mask = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    miscmp++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    drive(5'b0);
    cause_clr_we = 1'b0;
    cause_clr_mask = '0;
    repeat (3) @(negedge clk_cpu);

    // R1: reset state
    chk({5'b0, por_sync_n}, 6'd0, "R1 por_sync_n in reset");
    chk({5'b0, sys_rst_n},  6'd0, "R1 sys_rst_n in reset");
    chk({5'b0, cc_por_n},   6'd0, "R1 cc_por_n in reset");
    chk({5'b0, fab_rst_n},  6'd0, "R1 fab_rst_n in reset");
    chk(cause_flags, 6'b000001, "R1 flags in reset");

    // R2: release in the processor domain
    por_n = 1'b1;
    step();
    chk({5'b0, por_sync_n}, 6'd0, "R2 por_sync_n after 1 edge");
    chk({5'b0, sys_rst_n},  6'd0, "R2 sys_rst_n after 1 edge");
    step();
    chk({5'b0, por_sync_n}, 6'd1, "R2 por_sync_n after 2 edges");
    chk({5'b0, sys_rst_n},  6'd1, "R2 sys_rst_n after 2 edges");
    repeat (4) step();

    // R7: zero mask does nothing, masked bit clears
    clear_flags(6'b000000);
    chk(cause_flags, 6'b000001, "R7 zero mask keeps flags");
    clear_flags(6'b000001);
    chk(cause_flags, 6'b000000, "R7 power-on flag cleared");

    // table walk: R4, R5, R6, R3
    for (int v = 0; v < N_VEC; v++) begin
      logic [4:0] pat;
      int h;
      pat = VEC_TBL[v][12:8];
      h   = int'(VEC_TBL[v][7:0]);
      drive(pat);
      for (int k = 1; k <= h + 2 * SYNC + 1 + HOLD; k++) begin
        step();
        if (k == h) drive(5'b0);
        if (k == 2) chk({5'b0, sys_rst_n}, 6'd1, "R4 sys_rst_n before edge 3");
        if (k == 3) begin
          chk({5'b0, sys_rst_n}, 6'd0, "R4 sys_rst_n after edge 3");
          chk({5'b0, fab_rst_n}, 6'd0, "R4 fab_rst_n after edge 3");
          chk({5'b0, cc_por_n},  6'd1, "R3 cc_por_n unaffected");
          chk(cause_flags, {pat, 1'b0}, "R6 flags set with reset");
        end
        if (k == h + 2 * SYNC + HOLD) chk({5'b0, sys_rst_n}, 6'd0, "R5 sys_rst_n still held");
      end
      chk({5'b0, sys_rst_n}, 6'd1, "R5 sys_rst_n released");
      chk(cause_flags, {pat, 1'b0}, "R7 flags survive warm reset");
      clear_flags(6'b111111);
      chk(cause_flags, 6'd0, "R7 flags cleared by mask");
      repeat (4) step();
      chk({5'b0, fab_rst_n}, 6'd1, "R4 fab_rst_n released");
    end

    // R7: set wins over a same-cycle clear
    drive(5'b00001);
    repeat (4) step();
    clear_flags(6'b000010);
    chk(cause_flags, 6'b000010, "R7 set wins over clear");
    drive(5'b0);
    repeat (2 * SYNC + HOLD + 3) step();
    chk(cause_flags, 6'b000010, "R7 flag kept after source drops");

    // R1: cold reset mid-run, flags back to power-on only
    #3 por_n = 1'b0;
    #1;
    chk({5'b0, sys_rst_n}, 6'd0, "R1 sys_rst_n asynchronous");
    chk({5'b0, cc_por_n},  6'd0, "R1 cc_por_n asynchronous");
    chk({5'b0, fab_rst_n}, 6'd0, "R1 fab_rst_n asynchronous");
    chk(cause_flags, 6'b000001, "R1 flags re-initialised");
    repeat (3) @(negedge clk_cpu);
    #2 por_n = 1'b1;

    // R2: release in the clock-controller and fabric domains
    fork
      begin
        @(posedge clk_cc); #1;
        chk({5'b0, cc_por_n}, 6'd0, "R2 cc_por_n after 1 edge");
        @(posedge clk_cc); #1;
        chk({5'b0, cc_por_n}, 6'd1, "R2 cc_por_n after 2 edges");
      end
      begin
        @(posedge clk_fab); #1;
        chk({5'b0, fab_rst_n}, 6'd0, "R2 fab_rst_n after 1 edge");
        @(posedge clk_fab); #1;
        chk({5'b0, fab_rst_n}, 6'd1, "R2 fab_rst_n after 2 edges");
      end
    join

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule